// File: doc/BRIEF.md
# Clock Multiplier Control Register with Lock Monitor

This block is a 16-bit control and status register that sits next to an on-chip clock multiplier. Software writes it through a one-cycle write strobe and can read its contents back at any time. The stored fields drive the multiplier's control pins: the multiplication rate, a divide-by-two ahead of the multiplier, the oscillator power-down, the choice between the multiplied clock and the raw input clock, and a route of the oscillator output to a test pin. Four more bits hold the top nibble of a 20-bit interpolator rate word and are passed out unchanged.

A sticky lock flag lets software check that the multiplier stayed locked over a period of time. Software pulses a test bit: it writes it to 1 and then to 0. While the test bit is 1 the flag is held at 1. Once the test bit is 0, any loss of the lock indicator clears the flag, and the flag stays clear until the next test pulse. The lock indicator arrives asynchronously and passes through a synchronizer first.

A rate field of zero means the oscillator is off. In that case power-down is asserted and the clock select is forced to the input clock, whatever the select bit holds.

Top module: `pll_ctl_reg`

## Requirements
- R1: After reset, rd_data is 0, rate_ctl is 0, vco_pd is 1, and sysclk_sel_vco, in_div2_en, vco_test_route and ifreq_hi are 0.
- R2: A write with wr_en high stores these fields, and rd_data returns each of them on the cycle after the write edge: bit 12 (test), bit 11 (test route), bit 9 (clock select), bit 8 (pre-divide), bits 7:4 (rate) and bits 3:0 (interpolator nibble).
- R3: Bits 15, 14 and 10 always read 0. Bit 13 returns the lock flag and is never taken from wr_data.
- R4: rate_ctl equals bits 7:4, so the multiplication factor is that value plus one. vco_pd is 1 exactly when bits 7:4 are zero.
- R5: sysclk_sel_vco is 1 only when bit 9 is 1 and bits 7:4 are nonzero. A zero rate forces it to 0.
- R6: in_div2_en follows bit 8, vco_test_route follows bit 11, and ifreq_hi follows bits 3:0.
- R7: While bit 12 is stored as 1, the lock flag (bit 13) reads 1 from the following cycle on, even if pll_locked is low.
- R8: While bit 12 is 0, pll_locked going low clears the flag within SYNC_STAGES+1 cycles. The flag stays 0 after lock returns, until bit 12 is set again.
- R9: After a test pulse, the flag stays 1 for as long as pll_locked stays high.
- R10: When wr_en is low, no stored field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read-back of the register, including the lock flag in bit 13 |
| pll_locked | input | 1 | Lock indicator from the multiplier, asynchronous |
| rate_ctl | output | 4 | Multiplier rate field (factor = value + 1) |
| in_div2_en | output | 1 | Enables the divide-by-two on the input clock |
| vco_pd | output | 1 | Oscillator power-down |
| sysclk_sel_vco | output | 1 | 1 selects the multiplied clock, 0 the input clock |
| vco_test_route | output | 1 | Routes the oscillator output to the test pin |
| ifreq_hi | output | 4 | Interpolator rate bits 19 to 16 |

## Verification
A table of write words covers the fields one at a time and in combination: rate zero against nonzero, the select bit with and without a zero rate, and the reserved bits set. These separate a correct forced bypass from a plain copy of the select bit, and show reserved-bit masking apart from storage. Directed sequences then run the lock flag through a test pulse with lock held, a loss of lock after the pulse, the return of lock (the flag must stay 0), a test with lock already low, and writes that try to set bit 13 directly. Together these separate sticky clearing from a flag that simply follows the lock input.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int REG_W   = 16;
  localparam int RATE_W  = 4;
  localparam int IFRQ_W  = 4;

  localparam int POS_FLAG  = 13;
  localparam int POS_TEST  = 12;
  localparam int POS_ROUTE = 11;
  localparam int POS_SEL   = 9;
  localparam int POS_DIV   = 8;
  localparam int POS_RATE  = 4;
  localparam int POS_IFRQ  = 0;

  typedef struct packed {
    logic              test;
    logic              route;
    logic              sel;
    logic              div2;
    logic [RATE_W-1:0] rate;
    logic [IFRQ_W-1:0] ifreq;
  } pllc_cfg_t;
endpackage

// File: rtl/pllc_rst_sync.sv
module pllc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pllc_cfg_reg.sv
module pllc_cfg_reg
  import pllc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output pllc_cfg_t        cfg
);
  pllc_cfg_t cfg_q;
  pllc_cfg_t cfg_d;
  pllc_cfg_t wr_fields;

  always_comb begin
    wr_fields.test  = wr_data[POS_TEST];
    wr_fields.route = wr_data[POS_ROUTE];
    wr_fields.sel   = wr_data[POS_SEL];
    wr_fields.div2  = wr_data[POS_DIV];
    wr_fields.rate  = wr_data[POS_RATE +: RATE_W];
    wr_fields.ifreq = wr_data[POS_IFRQ +: IFRQ_W];
  end

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_fields;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/pllc_lock_mon.sv
module pllc_lock_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  input  logic test_arm,
  output logic lock_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   lock_s;
  logic                   flag_q;
  logic                   flag_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = lock_async;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], lock_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign lock_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    flag_d = flag_q;
    if (test_arm)     flag_d = 1'b1;
    else if (!lock_s) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign lock_flag = flag_q;
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pllc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              pll_locked,
  output logic [RATE_W-1:0] rate_ctl,
  output logic              in_div2_en,
  output logic              vco_pd,
  output logic              sysclk_sel_vco,
  output logic              vco_test_route,
  output logic [IFRQ_W-1:0] ifreq_hi
);
  logic      rst_n_int;
  pllc_cfg_t cfg;
  logic      lock_flag;
  logic      rate_zero;

  pllc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  pllc_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .cfg    (cfg)
  );

  pllc_lock_mon #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .lock_async(pll_locked),
    .test_arm  (cfg.test),
    .lock_flag (lock_flag)
  );

  always_comb begin
    rate_zero      = (cfg.rate == '0);
    rate_ctl       = cfg.rate;
    vco_pd         = rate_zero;
    sysclk_sel_vco = cfg.sel & ~rate_zero;
    in_div2_en     = cfg.div2;
    vco_test_route = cfg.route;
    ifreq_hi       = cfg.ifreq;
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[POS_FLAG]            = lock_flag;
    rd_data[POS_TEST]            = cfg.test;
    rd_data[POS_ROUTE]           = cfg.route;
    rd_data[POS_SEL]             = cfg.sel;
    rd_data[POS_DIV]             = cfg.div2;
    rd_data[POS_RATE +: RATE_W]  = cfg.rate;
    rd_data[POS_IFRQ +: IFRQ_W]  = cfg.ifreq;
  end
endmodule

// File: rtl/pll_ctl_reg_chk.sv
module pll_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] rd_data,
  input logic        vco_pd,
  input logic        sysclk_sel_vco
);
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:14] == 2'b00) && !rd_data[10]);

  // R5
  bypass_when_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vco_pd |-> !sysclk_sel_vco);

  // R7
  test_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[12] |=> rd_data[13]);

  // R8
  flag_sticky_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[13] && !rd_data[12]) |=> !rd_data[13]);

  // R8
  flag_fall_untested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[13]) |-> !$past(rd_data[12]));

  // R10
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({rd_data[12:11], rd_data[9:0]}));
endmodule

bind pll_ctl_reg pll_ctl_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .rd_data       (rd_data),
  .vco_pd        (vco_pd),
  .sysclk_sel_vco(sysclk_sel_vco)
);

// File: tb/pll_ctl_reg_bench.sv
module pll_ctl_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int NVEC = 8;

  localparam logic [15:0] VEC_W [NVEC] = '{
    16'h0000, 16'h0230, 16'h0200, 16'h0170,
    16'h08F5, 16'hE40A, 16'h0B9C, 16'h2000
  };
  localparam logic [15:0] VEC_R [NVEC] = '{
    16'h0000, 16'h0230, 16'h0200, 16'h0170,
    16'h08F5, 16'h000A, 16'h0B9C, 16'h0000
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pll_locked = 1'b1;
  logic [15:0] rd_data;
  logic [3:0]  rate_ctl;
  logic        in_div2_en, vco_pd, sysclk_sel_vco, vco_test_route;
  logic [3:0]  ifreq_hi;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctl_reg #(.SYNC_STAGES(SYNC)) u_pll_ctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pll_locked(pll_locked), .rate_ctl(rate_ctl),
    .in_div2_en(in_div2_en), .vco_pd(vco_pd), .sysclk_sel_vco(sysclk_sel_vco),
    .vco_test_route(vco_test_route), .ifreq_hi(ifreq_hi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'hFFFF;
  endtask

  task automatic check_outs(input logic [15:0] w);
    logic [3:0] r;
    r = w[7:4];
    check("R4 rate", rate_ctl, r);
    check("R4 pd", vco_pd, (r == 0));
    check("R5 sel", sysclk_sel_vco, w[9] && (r != 0));
    check("R6 div", in_div2_en, w[8]);
    check("R6 route", vco_test_route, w[11]);
    check("R6 ifreq", ifreq_hi, w[3:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 rd", rd_data, 16'h0000);
    check("R1 pd", vco_pd, 1'b1);
    check("R1 outs", {rate_ctl, sysclk_sel_vco, in_div2_en, vco_test_route, ifreq_hi}, '0);

    // R2 R3 R4 R5 R6 table walk (bit 12 clear, bit 13 masked as flag)
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC_W[k]);
      check("R2/R3 readback", rd_data & 16'hDFFF, VEC_R[k]);
      check_outs(VEC_W[k]);
    end
    check("R3 flag not written", rd_data[13], 1'b0);

    // R10 no change without strobe
    wr(16'h0B9C);
    wr_data = 16'h0000;
    idle(3);
    check("R10 hold", rd_data & 16'hDFFF, 16'h0B9C);

    // R7 test pulse with lock high
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h1030;
    @(negedge clk); wr_en = 1'b0;
    check("R2 test bit", rd_data[12], 1'b1);
    @(negedge clk);
    check("R7 flag set", rd_data[13], 1'b1);
    wr(16'h0030);
    idle(5);
    check("R9 flag held", rd_data[13], 1'b1);

    // R8 loss of lock clears, sticky after return
    pll_locked = 1'b0;
    idle(SYNC + 2);
    check("R8 cleared", rd_data[13], 1'b0);
    pll_locked = 1'b1;
    idle(5);
    check("R8 sticky", rd_data[13], 1'b0);

    // R7 test with lock low forces 1
    pll_locked = 1'b0;
    idle(SYNC + 1);
    wr(16'h1030);
    idle(2);
    check("R7 forced while low", rd_data[13], 1'b1);
    wr(16'h0030);
    idle(2);
    check("R8 clear after test ends", rd_data[13], 1'b0);
    pll_locked = 1'b1;

    // R3 direct write to bit 13 ignored
    wr(16'h2030);
    idle(2);
    check("R3 bit13 write", rd_data[13], 1'b0);

    // R5 zero rate overrides select
    wr(16'h0300);
    check("R5 forced bypass", {sysclk_sel_vco, vco_pd}, 2'b01);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset", rd_data, 16'h0000);
    rst_n = 1'b1;
    idle(4);
    check("R1 after release pd", vco_pd, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule